// File: doc/BRIEF.md
# Chunked Configuration Transfer Controller

This block moves one configuration bitstream at a time down a hierarchy of configuration memories. It accepts a request with a library base address, a length in bytes, a target core and a target level. It then cuts the bitstream into fixed 2 KB chunks. For each chunk it issues a chain of DMA descriptors, one per hop: from the external library into the shared local configuration memory, then into the core's private cache, then into the core's context. The chain stops at the level the request and the core allow.

Only one descriptor is outstanding at any time. The next one leaves only after the DMA engine has acknowledged the previous hop. The controller counts completed chunks and pulses done when the whole bitstream has arrived. An abort lets the chunk in flight finish and then stops. The controller remembers how far the aborted transfer got, per core. A later request for the same bitstream continues from the first chunk that is missing.

Two parameter masks describe the cores. One marks cores whose loader fetches its own configuration; prefetch for these stops at the cache. The other marks cores built without a cache; for these the cache hop is skipped.

Top module: `cfg_chunk_xfer`

## Requirements
- R1: The chunk count of a request is the byte length rounded up to a multiple of 2048, divided by 2048, and capped at 32. A final partial chunk is moved as a full chunk. A length of zero completes at once, with no descriptor.
- R2: Chunks are sent in ascending order. The descriptor address is base + 2048 × chunk index. No descriptor is presented between a hop's acceptance and its `ack`.
- R3: Level codes are 0 external, 1 local, 2 cache, 3 core context; a target of 0 means local. Each chunk always takes the hop 0→1. It then takes 1→2 when the core has a cache and the target is 2 or 3. It then takes a hop into 3 (from 2, or from 1 without a cache) when the target is 3.
- R4: For a core marked in the self-fetching loader mask, a target of 3 is lowered to 2. No descriptor of that core ever has destination 3.
- R5: For a core marked in the cacheless mask, the cache level is skipped. A target of 2 for such a core ends at local, and no descriptor of that core has destination 2.
- R6: While `desc_valid` is high and `desc_ready` low, the descriptor stays valid and its fields do not change.
- R7: An `abort` during a transfer lets the current chunk complete all its hops. Then `aborted` pulses and `prog_cnt` holds the number of completed chunks. An `abort` while idle has no effect on the next transfer.
- R8: After an abort, a request with the same core, base and effective level starts at the first chunk that was not completed. After a transfer completes, or after a request with a different bitstream for that core, the same request starts again from chunk 0.
- R9: `done` pulses for one cycle in the cycle after the last hop's `ack`. At that point `prog_cnt` equals `prog_total`. `done` and `aborted` are never high together.
- R10: After reset, `req_ready` is 1 and `desc_valid`, `done`, `aborted` and `prog_cnt` are 0. `req_ready` is high only when idle, and no descriptor is presented while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Controller idle, request taken |
| req_base | input | 32 | Library base address of the bitstream |
| req_len | input | 17 | Bitstream length in bytes |
| req_core | input | 2 | Target core index |
| req_level | input | 2 | Target level code |
| abort | input | 1 | Stop after the chunk in flight |
| desc_valid | output | 1 | Descriptor presented |
| desc_ready | input | 1 | DMA engine takes the descriptor |
| desc_src | output | 2 | Source level code of the hop |
| desc_dst | output | 2 | Destination level code of the hop |
| desc_core | output | 2 | Core the hop belongs to |
| desc_addr | output | 32 | Library address of the chunk |
| ack | input | 1 | DMA engine finished the accepted hop |
| done | output | 1 | Pulse: whole bitstream delivered |
| aborted | output | 1 | Pulse: transfer stopped by abort |
| prog_cnt | output | 6 | Chunks completed for the current or last request |
| prog_total | output | 6 | Chunk count of the current or last request |

## Verification
The hardest case to reach is an abort that lands while a chunk still has hops left, followed by a resume. The resume must start exactly at the saved chunk, then be forgotten once the transfer completes. To get there, the bench's DMA responder raises `abort` in the same cycle it accepts a chosen descriptor. Several more hop acknowledgements then follow before the stop, and the bench sends the identical request again, twice. The routing corners are reached by aiming at the self-fetching core and at the cacheless core with every target level.

// File: rtl/cfg_xfer_pkg.sv
package cfg_xfer_pkg;

    // Memory level codes; the hop order follows the numeric order.
    typedef enum logic [1:0] {
        LVL_EXT   = 2'd0,
        LVL_LOCAL = 2'd1,
        LVL_CACHE = 2'd2,
        LVL_CORE  = 2'd3
    } lvl_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } st_t;

    // Destination reached by the hop that leaves level src.
    function automatic lvl_t hop_target(lvl_t src, logic via_cache);
        lvl_t r;
        case (src)
            LVL_EXT:   r = LVL_LOCAL;
            LVL_LOCAL: r = via_cache ? LVL_CACHE : LVL_CORE;
            default:   r = LVL_CORE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cfg_chunk_count.sv
module cfg_chunk_count #(
    parameter int LEN_W      = 17,
    parameter int CHUNK_SH   = 11,
    parameter int MAX_CHUNKS = 32,
    parameter int CNT_W      = 6
) (
    input  logic [LEN_W-1:0] len_bytes,
    output logic [CNT_W-1:0] n_chunks
);
    localparam int SUM_W = LEN_W + 1;
    localparam logic [SUM_W-1:0] ROUND_ADD = SUM_W'((1 << CHUNK_SH) - 1);

    logic [SUM_W-1:0] sum_w;
    logic [SUM_W-1:0] raw_w;

    always_comb begin
        sum_w = {1'b0, len_bytes} + ROUND_ADD;
        raw_w = sum_w >> CHUNK_SH;
        if (raw_w > SUM_W'(MAX_CHUNKS)) begin
            n_chunks = CNT_W'(MAX_CHUNKS);
        end else begin
            n_chunks = CNT_W'(raw_w);
        end
    end

endmodule

// File: rtl/cfg_route.sv
module cfg_route
    import cfg_xfer_pkg::*;
#(
    parameter int                 N_CORES      = 3,
    parameter int                 CORE_W       = 2,
    parameter logic [N_CORES-1:0] ACTIVE_MASK  = 3'b010,
    parameter logic [N_CORES-1:0] NOCACHE_MASK = 3'b100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CORE_W-1:0] core,
    input  logic [1:0]        level,
    output lvl_t              eff_lvl,
    output logic              via_cache
);
    logic self_fetch;
    logic has_cache;
    lvl_t asked;

    // Unknown core indices are treated as self-fetching and cacheless.
    always_comb begin
        self_fetch = 1'b1;
        has_cache  = 1'b0;
        for (int i = 0; i < N_CORES; i++) begin
            if (core == CORE_W'(i)) begin
                self_fetch = ACTIVE_MASK[i];
                has_cache  = !NOCACHE_MASK[i];
            end
        end
    end

    always_comb begin
        asked = lvl_t'(level);
        if (asked == LVL_EXT) begin
            asked = LVL_LOCAL;
        end
        eff_lvl = asked;
        if (eff_lvl == LVL_CORE && self_fetch) begin
            eff_lvl = LVL_CACHE;
        end
        if (eff_lvl == LVL_CACHE && !has_cache) begin
            eff_lvl = LVL_LOCAL;
        end
        via_cache = has_cache && (eff_lvl != LVL_LOCAL);
    end

    AST_EFF_NOT_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        eff_lvl != LVL_EXT); // R3

endmodule

// File: rtl/cfg_resume_tbl.sv
module cfg_resume_tbl #(
    parameter int N_CORES = 3,
    parameter int CORE_W  = 2,
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CORE_W-1:0] lk_core,
    input  logic [ADDR_W-1:0] lk_base,
    input  logic [1:0]        lk_lvl,
    output logic              lk_hit,
    output logic [CNT_W-1:0]  lk_cnt,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic [CORE_W-1:0] wr_core,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [1:0]        wr_lvl,
    input  logic [CNT_W-1:0]  wr_cnt
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] base;
        logic [1:0]        lvl;
        logic [CNT_W-1:0]  cnt;
    } entry_t;

    entry_t ent_d [N_CORES];
    entry_t ent_q [N_CORES];

    for (genvar g = 0; g < N_CORES; g++) begin : g_ent
        always_comb begin
            ent_d[g] = ent_q[g];
            if (wr_core == CORE_W'(g)) begin
                if (wr_clr) begin
                    ent_d[g].valid = 1'b0;
                end
                if (wr_set) begin
                    ent_d[g].valid = 1'b1;
                    ent_d[g].base  = wr_base;
                    ent_d[g].lvl   = wr_lvl;
                    ent_d[g].cnt   = wr_cnt;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[g] <= '0;
            end else begin
                ent_q[g] <= ent_d[g];
            end
        end
    end

    always_comb begin
        lk_hit = 1'b0;
        lk_cnt = '0;
        for (int i = 0; i < N_CORES; i++) begin
            if (lk_core == CORE_W'(i) && ent_q[i].valid &&
                ent_q[i].base == lk_base && ent_q[i].lvl == lk_lvl) begin
                lk_hit = 1'b1;
                lk_cnt = ent_q[i].cnt;
            end
        end
    end

    AST_TBL_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set && wr_clr)); // R8

endmodule

// File: rtl/cfg_chunk_xfer.sv
module cfg_chunk_xfer
    import cfg_xfer_pkg::*;
#(
    parameter int                 ADDR_W       = 32,
    parameter int                 LEN_W        = 17,
    parameter int                 N_CORES      = 3,
    parameter int                 CHUNK_SH     = 11,
    parameter int                 MAX_CHUNKS   = 32,
    parameter logic [N_CORES-1:0] ACTIVE_MASK  = 3'b010,
    parameter logic [N_CORES-1:0] NOCACHE_MASK = 3'b100,
    localparam int                CORE_W       = (N_CORES > 1) ? $clog2(N_CORES) : 1,
    localparam int                CNT_W        = $clog2(MAX_CHUNKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [CORE_W-1:0] req_core,
    input  logic [1:0]        req_level,
    input  logic              abort,
    output logic              desc_valid,
    input  logic              desc_ready,
    output logic [1:0]        desc_src,
    output logic [1:0]        desc_dst,
    output logic [CORE_W-1:0] desc_core,
    output logic [ADDR_W-1:0] desc_addr,
    input  logic              ack,
    output logic              done,
    output logic              aborted,
    output logic [CNT_W-1:0]  prog_cnt,
    output logic [CNT_W-1:0]  prog_total
);
    typedef struct packed {
        st_t               st;
        lvl_t              src;
        lvl_t              eff;
        logic              via_cache;
        logic [CORE_W-1:0] core;
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  total;
        logic [CNT_W-1:0]  cnt;
        logic              abort_pend;
        logic              done;
        logic              aborted;
    } ctl_t;

    ctl_t s_d, s_q;

    logic [CNT_W-1:0]  req_chunks;
    lvl_t              req_eff;
    logic              req_via_cache;
    logic              rs_hit;
    logic [CNT_W-1:0]  rs_cnt;
    logic              tbl_set, tbl_clr;
    logic [CORE_W-1:0] tbl_core;
    logic [CNT_W-1:0]  tbl_cnt;
    lvl_t              hop_dst;
    logic              last_hop;
    logic [CNT_W-1:0]  cnt_inc;
    logic [CNT_W-1:0]  start_cnt;

    cfg_chunk_count #(
        .LEN_W(LEN_W), .CHUNK_SH(CHUNK_SH), .MAX_CHUNKS(MAX_CHUNKS), .CNT_W(CNT_W)
    ) u_count (
        .len_bytes(req_len),
        .n_chunks (req_chunks)
    );

    cfg_route #(
        .N_CORES(N_CORES), .CORE_W(CORE_W),
        .ACTIVE_MASK(ACTIVE_MASK), .NOCACHE_MASK(NOCACHE_MASK)
    ) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .core     (req_core),
        .level    (req_level),
        .eff_lvl  (req_eff),
        .via_cache(req_via_cache)
    );

    cfg_resume_tbl #(
        .N_CORES(N_CORES), .CORE_W(CORE_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
    ) u_resume (
        .clk    (clk),
        .rst_n  (rst_n),
        .lk_core(req_core),
        .lk_base(req_base),
        .lk_lvl (req_eff),
        .lk_hit (rs_hit),
        .lk_cnt (rs_cnt),
        .wr_set (tbl_set),
        .wr_clr (tbl_clr),
        .wr_core(tbl_core),
        .wr_base(s_q.base),
        .wr_lvl (s_q.eff),
        .wr_cnt (tbl_cnt)
    );

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        s_d.aborted = 1'b0;
        tbl_set     = 1'b0;
        tbl_clr     = 1'b0;
        tbl_core    = s_q.core;
        hop_dst     = hop_target(s_q.src, s_q.via_cache);
        last_hop    = (hop_dst == s_q.eff);
        cnt_inc     = s_q.cnt + CNT_W'(1);
        tbl_cnt     = cnt_inc;
        start_cnt   = rs_hit ? rs_cnt : '0;

        if (s_q.st != ST_IDLE && abort) begin
            s_d.abort_pend = 1'b1;
        end

        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.base       = req_base;
                    s_d.core       = req_core;
                    s_d.eff        = req_eff;
                    s_d.via_cache  = req_via_cache;
                    s_d.total      = req_chunks;
                    s_d.cnt        = start_cnt;
                    s_d.src        = LVL_EXT;
                    s_d.abort_pend = 1'b0;
                    tbl_core       = req_core;
                    if (start_cnt >= req_chunks) begin
                        s_d.cnt  = req_chunks;
                        s_d.done = 1'b1;
                        tbl_clr  = 1'b1;
                    end else begin
                        s_d.st  = ST_ISSUE;
                        tbl_clr = !rs_hit;
                    end
                end
            end
            ST_ISSUE: begin
                if (desc_ready) begin
                    s_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (ack) begin
                    if (!last_hop) begin
                        s_d.src = hop_dst;
                        s_d.st  = ST_ISSUE;
                    end else begin
                        s_d.cnt = cnt_inc;
                        s_d.src = LVL_EXT;
                        if (cnt_inc == s_q.total) begin
                            s_d.done = 1'b1;
                            s_d.st   = ST_IDLE;
                            tbl_clr  = 1'b1;
                        end else if (s_q.abort_pend || abort) begin
                            s_d.aborted = 1'b1;
                            s_d.st      = ST_IDLE;
                            tbl_set     = 1'b1;
                        end else begin
                            s_d.st = ST_ISSUE;
                        end
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready  = (s_q.st == ST_IDLE);
    assign desc_valid = (s_q.st == ST_ISSUE);
    assign desc_src   = s_q.src;
    assign desc_dst   = hop_dst;
    assign desc_core  = s_q.core;
    assign desc_addr  = s_q.base + (ADDR_W'(s_q.cnt) << CHUNK_SH);
    assign done       = s_q.done;
    assign aborted    = s_q.aborted;
    assign prog_cnt   = s_q.cnt;
    assign prog_total = s_q.total;

    // Core attributes of the descriptor on the port, for the routing checks.
    logic desc_self_fetch, desc_no_cache;
    always_comb begin
        desc_self_fetch = 1'b1;
        desc_no_cache   = 1'b1;
        for (int i = 0; i < N_CORES; i++) begin
            if (desc_core == CORE_W'(i)) begin
                desc_self_fetch = ACTIVE_MASK[i];
                desc_no_cache   = NOCACHE_MASK[i];
            end
        end
    end

    AST_DESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && !desc_ready |=> desc_valid && $stable(desc_addr) && $stable(desc_dst) && $stable(desc_src)); // R6
    AST_DONE_ABORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && aborted)); // R9
    AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> prog_cnt == prog_total); // R9
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        prog_cnt <= prog_total && prog_total <= CNT_W'(MAX_CHUNKS)); // R1
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> prog_cnt == $past(prog_cnt) || prog_cnt == $past(prog_cnt) + CNT_W'(1)); // R2
    AST_SELF_FETCH_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && desc_self_fetch |-> desc_dst != 2'(LVL_CORE)); // R4
    AST_NO_CACHE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && desc_no_cache |-> desc_dst != 2'(LVL_CACHE)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !desc_valid); // R10
    AST_HOP_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> desc_dst > desc_src); // R3

endmodule

// File: tb/cfg_chunk_xfer_test.sv
`timescale 1ns/1ps
module cfg_chunk_xfer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_base = '0;
    logic [16:0] req_len = '0;
    logic [1:0]  req_core = '0;
    logic [1:0]  req_level = '0;
    logic        abort = 1'b0;
    logic        desc_valid;
    logic        desc_ready = 1'b0;
    logic [1:0]  desc_src, desc_dst, desc_core;
    logic [31:0] desc_addr;
    logic        ack = 1'b0;
    logic        done, aborted;
    logic [5:0]  prog_cnt, prog_total;

    int total_chk = 0;
    int bad_chk = 0;

    logic [1:0]  rec_src  [0:127];
    logic [1:0]  rec_dst  [0:127];
    logic [1:0]  rec_core [0:127];
    logic [31:0] rec_addr [0:127];
    int n_desc;
    bit got_done, got_abort;

    always #5 clk = ~clk;

    cfg_chunk_xfer uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_base(req_base),
        .req_len(req_len), .req_core(req_core), .req_level(req_level),
        .abort(abort),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_src(desc_src),
        .desc_dst(desc_dst), .desc_core(desc_core), .desc_addr(desc_addr),
        .ack(ack), .done(done), .aborted(aborted),
        .prog_cnt(prog_cnt), .prog_total(prog_total)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total_chk++;
        if (!ok) begin
            bad_chk++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Issue one request and act as the DMA engine until done or aborted.
    task automatic run_req(input logic [31:0] base, input int len, input logic [1:0] core,
                           input logic [1:0] lvl, input int abort_at, input int stall);
        int cyc;
        logic [31:0] held;
        n_desc = 0;
        got_done = 0;
        got_abort = 0;
        cyc = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_base  = base;
        req_len   = 17'(len);
        req_core  = core;
        req_level = lvl;
        @(negedge clk);
        req_valid = 1'b0;
        while (!got_done && !got_abort && cyc < 5000) begin
            if (done) begin
                got_done = 1;
            end else if (aborted) begin
                got_abort = 1;
            end else if (desc_valid) begin
                rec_src[n_desc]  = desc_src;
                rec_dst[n_desc]  = desc_dst;
                rec_core[n_desc] = desc_core;
                rec_addr[n_desc] = desc_addr;
                if (stall > 0 && n_desc == 0) begin
                    held = desc_addr;
                    for (int k = 0; k < stall; k++) begin
                        @(negedge clk);
                        chk(desc_valid == 1'b1 && desc_addr == held, "R6 hold", desc_addr, held);
                    end
                end
                desc_ready = 1'b1;
                if (n_desc == abort_at) abort = 1'b1;
                n_desc++;
                @(negedge clk);
                desc_ready = 1'b0;
                abort = 1'b0;
                repeat (2) begin
                    @(negedge clk);
                    chk(desc_valid == 1'b0, "R2 no desc before ack", desc_valid, 0);
                end
                ack = 1'b1;
                @(negedge clk);
                ack = 1'b0;
            end else begin
                @(negedge clk);
            end
            cyc++;
        end
    endtask

    // Independent model of the hop list for a core and target level.
    task automatic check_run(input string tag, input logic [31:0] base, input logic [1:0] core,
                             input logic [1:0] lvl, input int first, input int nch);
        int nh;
        int es [0:2];
        int ed [0:2];
        int eff;
        bit self_fetch, has_cache;
        bit ok;
        self_fetch = (core == 2'd1) || (core == 2'd3);
        has_cache  = (core == 2'd0) || (core == 2'd1);
        eff = (lvl == 2'd0) ? 1 : int'(lvl);
        if (eff == 3 && self_fetch) eff = 2;
        if (eff == 2 && !has_cache) eff = 1;
        nh = 0;
        es[nh] = 0; ed[nh] = 1; nh++;
        if (eff >= 2 && has_cache) begin es[nh] = 1; ed[nh] = 2; nh++; end
        if (eff == 3) begin es[nh] = has_cache ? 2 : 1; ed[nh] = 3; nh++; end
        chk(n_desc == nch * nh, {tag, " descriptor count"}, n_desc, nch * nh);
        ok = 1;
        for (int i = 0; i < n_desc && i < nch * nh; i++) begin
            int c;
            int h;
            c = first + i / nh;
            h = i % nh;
            if (rec_src[i] != 2'(es[h]) || rec_dst[i] != 2'(ed[h]) || rec_core[i] != core ||
                rec_addr[i] != base + 32'(c) * 32'd2048) begin
                ok = 0;
                $display("FAIL %s hop %0d: actual src=%0d dst=%0d addr=%0h expected src=%0d dst=%0d addr=%0h",
                         tag, i, rec_src[i], rec_dst[i], rec_addr[i], es[h], ed[h],
                         base + 32'(c) * 32'd2048);
            end
        end
        total_chk++;
        if (!ok) bad_chk++;
    endtask

    task automatic t_reset;
        chk(req_ready == 1'b1, "R10 req_ready", req_ready, 1);
        chk(desc_valid == 1'b0 && done == 1'b0 && aborted == 1'b0, "R10 outputs quiet",
            {desc_valid, done, aborted}, 0);
        chk(prog_cnt == 6'd0, "R10 prog_cnt", prog_cnt, 0);
    endtask

    task automatic t_full_path;
        run_req(32'h0001_0000, 4096, 2'd0, 2'd3, -1, 0);
        chk(got_done, "R9 done", got_done, 1);
        check_run("R3 full path", 32'h0001_0000, 2'd0, 2'd3, 0, 2);
        chk(prog_cnt == 6'd2 && prog_total == 6'd2, "R9 progress", prog_cnt, 2);
        chk(req_ready == 1'b1, "R10 idle after done", req_ready, 1);
    endtask

    task automatic t_rounding;
        run_req(32'h0002_0000, 2049, 2'd0, 2'd1, -1, 0);
        check_run("R1 partial chunk", 32'h0002_0000, 2'd0, 2'd1, 0, 2);
        chk(prog_total == 6'd2, "R1 total 2049", prog_total, 2);
        run_req(32'h0002_8000, 2048, 2'd0, 2'd0, -1, 0);
        check_run("R3 level0 as local", 32'h0002_8000, 2'd0, 2'd0, 0, 1);
        chk(prog_total == 6'd1, "R1 total 2048", prog_total, 1);
    endtask

    task automatic t_self_fetch;
        run_req(32'h0003_0000, 6144, 2'd1, 2'd3, -1, 0);
        chk(got_done, "R4 done", got_done, 1);
        check_run("R4 stop at cache", 32'h0003_0000, 2'd1, 2'd3, 0, 3);
    endtask

    task automatic t_no_cache;
        run_req(32'h0004_0000, 2048, 2'd2, 2'd3, -1, 0);
        check_run("R5 skip cache to core", 32'h0004_0000, 2'd2, 2'd3, 0, 1);
        run_req(32'h0004_8000, 3000, 2'd2, 2'd2, -1, 0);
        check_run("R5 cache target ends local", 32'h0004_8000, 2'd2, 2'd2, 0, 2);
    endtask

    task automatic t_sizes;
        run_req(32'h0005_0000, 0, 2'd0, 2'd3, -1, 0);
        chk(got_done && n_desc == 0, "R1 zero length", n_desc, 0);
        chk(prog_total == 6'd0, "R1 zero total", prog_total, 0);
        run_req(32'h0006_0000, 65536, 2'd0, 2'd1, -1, 0);
        check_run("R1 64KB", 32'h0006_0000, 2'd0, 2'd1, 0, 32);
        run_req(32'h0008_0000, 100000, 2'd0, 2'd1, -1, 0);
        check_run("R1 capped", 32'h0008_0000, 2'd0, 2'd1, 0, 32);
        chk(prog_total == 6'd32, "R1 cap total", prog_total, 32);
    endtask

    task automatic t_stall;
        run_req(32'h0009_0000, 2048, 2'd0, 2'd2, -1, 3);
        check_run("R6 stalled path", 32'h0009_0000, 2'd0, 2'd2, 0, 1);
    endtask

    task automatic t_abort_resume;
        // Target core on core 0: three hops per chunk; abort on the first hop of chunk 1.
        run_req(32'h000A_0000, 5 * 2048, 2'd0, 2'd3, 3, 0);
        chk(got_abort && !got_done, "R7 aborted", got_abort, 1);
        chk(n_desc == 6, "R7 chunk in flight finishes", n_desc, 6);
        chk(prog_cnt == 6'd2, "R7 completed chunks", prog_cnt, 2);
        run_req(32'h000A_0000, 5 * 2048, 2'd0, 2'd3, -1, 0);
        chk(got_done, "R8 resume done", got_done, 1);
        check_run("R8 resume from chunk 2", 32'h000A_0000, 2'd0, 2'd3, 2, 3);
        chk(prog_cnt == 6'd5, "R8 resume progress", prog_cnt, 5);
        run_req(32'h000A_0000, 5 * 2048, 2'd0, 2'd3, -1, 0);
        check_run("R8 restart after done", 32'h000A_0000, 2'd0, 2'd3, 0, 5);
        // An abort, then a different bitstream on the same core drops the saved point.
        run_req(32'h000B_0000, 3 * 2048, 2'd1, 2'd2, 0, 0);
        chk(got_abort && prog_cnt == 6'd1, "R7 abort first chunk", prog_cnt, 1);
        run_req(32'h000C_0000, 2048, 2'd1, 2'd2, -1, 0);
        run_req(32'h000B_0000, 3 * 2048, 2'd1, 2'd2, -1, 0);
        check_run("R8 entry dropped", 32'h000B_0000, 2'd1, 2'd2, 0, 3);
    endtask

    task automatic t_idle_abort;
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(aborted == 1'b0, "R7 idle abort no pulse", aborted, 0);
        run_req(32'h000D_0000, 4096, 2'd0, 2'd1, -1, 0);
        chk(got_done && !got_abort, "R7 idle abort ignored", got_done, 1);
        check_run("R7 idle abort path", 32'h000D_0000, 2'd0, 2'd1, 0, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_path();
        t_rounding();
        t_self_fetch();
        t_no_cache();
        t_sizes();
        t_stall();
        t_abort_resume();
        t_idle_abort();
        $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
        $finish;
    end

    initial begin
        #(200000 * 10);
        total_chk++;
        bad_chk++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
        $finish;
    end

endmodule